// File: doc/BRIEF.md
# Quad Serial Channel Address Decoder

This block sits between an 8-bit host bus and four asynchronous serial channel cores on one adapter card. It compares the upper address bits against a bank of base-address switches and produces one chip select per channel, each channel owning eight consecutive register addresses. It forwards the register offset and the read and write strobes to the channel cores. It steers the addressed channel's read data onto the host data bus.

The block also collects the four channel interrupt requests into a shared status byte and a single gated interrupt output. When the status-mode switch is on, a host read of any channel's scratchpad offset (offset 7) returns that status byte, and the addressed channel is not selected. Writes to that offset still reach the channel's own scratchpad. The block also registers one transmit-driver enable per channel for the differential line drivers.

Top module: `serial_card_decoder`

## Requirements
- R1: The card responds only when every address bit `addr_i[15:5]` satisfies its switch: a switch bit of 1 (ON) requires the address bit to be 0, and a switch bit of 0 (OFF) requires it to be 1. With no match, `ch_cs_o`, `ch_rd_o`, `ch_wr_o`, `rdata_oe_o` and `rdata_o` are all 0.
- R2: On a match, channel n = `addr_i[4:3]` is addressed, so channel n covers base + 8·n to base + 8·n + 7. `ch_cs_o` is one-hot with bit n set, except in the case R6 names.
- R3: `ch_reg_o` equals `addr_i[2:0]` at all times. `ch_rd_o` equals `rd_i` and `ch_wr_o` equals `wr_i` whenever the card responds, except that R6 suppresses `ch_rd_o`.
- R4: On a responding read that is not a status override, `rdata_oe_o` is 1 and `rdata_o` carries the addressed channel's byte from `ch_rdata_i[8n+7:8n]`, in the same cycle.
- R5: Bit n of the status byte holds channel n's request as sampled at the previous rising clock edge. Bits 7:4 are 0.
- R6: With `status_mode_i` at 1, a responding read at offset 7 returns the status byte on `rdata_o` with `rdata_oe_o` at 1, and `ch_cs_o` and `ch_rd_o` are 0.
- R7: With `status_mode_i` at 0, a read at offset 7 behaves as in R4 and returns the channel's own scratchpad byte.
- R8: A responding write at offset 7 asserts `ch_wr_o` and the channel's chip select, whatever the value of `status_mode_i`.
- R9: `irq_o` is the OR of the four status bits, ANDed with `irq_gate_i`.
- R10: `drv_en_o[n]` equals `drv_ctl_i[n]` as sampled at the previous rising clock edge. A 1 enables channel n's transmit driver; a 0 puts it into high impedance.
- R11: While `rst_ni` is low, the status byte, `irq_o` and `drv_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Host I/O address |
| rd_i | input | 1 | Host read strobe |
| wr_i | input | 1 | Host write strobe |
| base_sw_i | input | 11 | Base-address switches for address bits 15:5; 1 = ON |
| status_mode_i | input | 1 | Status-mode switch; 1 = status byte replaces scratchpad on reads |
| ch_rdata_i | input | 32 | Read data of the channels, 8 bits each, channel 0 in the low byte |
| ch_irq_i | input | 4 | Interrupt request of each channel |
| irq_gate_i | input | 1 | Global enable for the shared interrupt |
| drv_ctl_i | input | 4 | Driver-enable control bit of each channel |
| ch_cs_o | output | 4 | Chip select of each channel |
| ch_reg_o | output | 3 | Register offset within the channel |
| ch_rd_o | output | 1 | Read strobe to the channels |
| ch_wr_o | output | 1 | Write strobe to the channels |
| rdata_o | output | 8 | Data returned to the host |
| rdata_oe_o | output | 1 | Card drives the host data bus |
| irq_o | output | 1 | Shared interrupt request |
| drv_en_o | output | 4 | Transmit-driver enable of each channel |

## Verification
Address decode, strobes, chip selects and read data are combinational, so they are due in the same cycle as the address and strobes. The status byte, `irq_o` and `drv_en_o` are due one rising edge after their inputs change. The bench drives every input between edges and samples 2 ns after the following rising edge. At that point both the combinational results for the current inputs and the registered copies of the inputs driven before that edge are settled. A separate check changes the interrupt requests mid-cycle and reads the status byte before and after the next edge, which pins the one-cycle latency.

// File: rtl/serial_card_pkg.sv
package serial_card_pkg;
  localparam int ADDR_W      = 16;
  localparam int NUM_CH      = 4;
  localparam int DATA_W      = 8;
  localparam int REG_AW      = 3;
  localparam int CH_AW       = $clog2(NUM_CH);
  localparam int BASE_W      = ADDR_W - REG_AW - CH_AW;
  localparam int SCRATCH_OFS = (1 << REG_AW) - 1;
endpackage

// File: rtl/scd_addr_decode.sv
module scd_addr_decode #(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 4,
  parameter int REG_AW = 3,
  localparam int CH_AW  = $clog2(NUM_CH),
  localparam int BASE_W = ADDR_W - REG_AW - CH_AW
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BASE_W-1:0] base_sw_i,
  output logic              hit_o,
  output logic [NUM_CH-1:0] ch_sel_o,
  output logic [REG_AW-1:0] reg_ofs_o
);
  logic [BASE_W-1:0] bit_ok;
  logic [CH_AW-1:0]  ch_idx;

  // switch ON (1) demands a 0 on the address line, OFF demands a 1
  for (genvar b = 0; b < BASE_W; b++) begin : g_bit
    assign bit_ok[b] = addr_i[REG_AW+CH_AW+b] ^ base_sw_i[b];
  end

  assign hit_o     = &bit_ok;
  assign ch_idx    = addr_i[REG_AW +: CH_AW];
  assign reg_ofs_o = addr_i[REG_AW-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign ch_sel_o[c] = hit_o && (ch_idx == CH_AW'(c));
  end
endmodule

// File: rtl/scd_irq_collect.sv
module scd_irq_collect #(
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] ch_irq_i,
  input  logic              irq_gate_i,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= ch_irq_i;
  end

  if (DATA_W > NUM_CH) begin : g_pad
    assign status_o = {{(DATA_W-NUM_CH){1'b0}}, irq_q};
  end else begin : g_nopad
    assign status_o = irq_q[DATA_W-1:0];
  end

  assign irq_o = irq_gate_i && (|irq_q);
endmodule

// File: rtl/scd_read_path.sv
module scd_read_path #(
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 8,
  parameter int REG_AW      = 3,
  parameter int SCRATCH_OFS = 7
) (
  input  logic                     rd_i,
  input  logic                     hit_i,
  input  logic [NUM_CH-1:0]        ch_sel_i,
  input  logic [REG_AW-1:0]        reg_ofs_i,
  input  logic                     status_mode_i,
  input  logic [DATA_W-1:0]        status_i,
  input  logic [NUM_CH*DATA_W-1:0] ch_rdata_i,
  output logic                     override_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rdata_oe_o
);
  logic [DATA_W-1:0] ch_byte;

  always_comb begin
    ch_byte = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel_i[c]) ch_byte = ch_rdata_i[c*DATA_W +: DATA_W];
    end
  end

  assign override_o = rd_i && hit_i && status_mode_i &&
                      (reg_ofs_i == REG_AW'(SCRATCH_OFS));
  assign rdata_oe_o = rd_i && hit_i;

  always_comb begin
    if (!rdata_oe_o)     rdata_o = '0;
    else if (override_o) rdata_o = status_i;
    else                 rdata_o = ch_byte;
  end
endmodule

// File: rtl/scd_drv_ctl.sv
module scd_drv_ctl #(
  parameter int NUM_CH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] drv_ctl_i,
  output logic [NUM_CH-1:0] drv_en_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) drv_en_o[c] <= 1'b0;
      else         drv_en_o[c] <= drv_ctl_i[c];
    end
  end
endmodule

// File: rtl/serial_card_decoder.sv
module serial_card_decoder
  import serial_card_pkg::*;
#(
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_NUM_CH = NUM_CH,
  parameter int P_DATA_W = DATA_W,
  parameter int P_REG_AW = REG_AW,
  localparam int L_CH_AW   = $clog2(P_NUM_CH),
  localparam int L_BASE_W  = P_ADDR_W - P_REG_AW - L_CH_AW,
  localparam int L_SCRATCH = (1 << P_REG_AW) - 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [P_ADDR_W-1:0]          addr_i,
  input  logic                         rd_i,
  input  logic                         wr_i,
  input  logic [L_BASE_W-1:0]          base_sw_i,
  input  logic                         status_mode_i,
  input  logic [P_NUM_CH*P_DATA_W-1:0] ch_rdata_i,
  input  logic [P_NUM_CH-1:0]          ch_irq_i,
  input  logic                         irq_gate_i,
  input  logic [P_NUM_CH-1:0]          drv_ctl_i,
  output logic [P_NUM_CH-1:0]          ch_cs_o,
  output logic [P_REG_AW-1:0]          ch_reg_o,
  output logic                         ch_rd_o,
  output logic                         ch_wr_o,
  output logic [P_DATA_W-1:0]          rdata_o,
  output logic                         rdata_oe_o,
  output logic                         irq_o,
  output logic [P_NUM_CH-1:0]          drv_en_o
);
  logic                hit;
  logic                override;
  logic [P_NUM_CH-1:0] ch_sel;
  logic [P_DATA_W-1:0] status;

  scd_addr_decode #(
    .ADDR_W (P_ADDR_W),
    .NUM_CH (P_NUM_CH),
    .REG_AW (P_REG_AW)
  ) i_decode (
    .addr_i    (addr_i),
    .base_sw_i (base_sw_i),
    .hit_o     (hit),
    .ch_sel_o  (ch_sel),
    .reg_ofs_o (ch_reg_o)
  );

  scd_irq_collect #(
    .NUM_CH (P_NUM_CH),
    .DATA_W (P_DATA_W)
  ) i_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ch_irq_i   (ch_irq_i),
    .irq_gate_i (irq_gate_i),
    .status_o   (status),
    .irq_o      (irq_o)
  );

  scd_read_path #(
    .NUM_CH      (P_NUM_CH),
    .DATA_W      (P_DATA_W),
    .REG_AW      (P_REG_AW),
    .SCRATCH_OFS (L_SCRATCH)
  ) i_read (
    .rd_i          (rd_i),
    .hit_i         (hit),
    .ch_sel_i      (ch_sel),
    .reg_ofs_i     (ch_reg_o),
    .status_mode_i (status_mode_i),
    .status_i      (status),
    .ch_rdata_i    (ch_rdata_i),
    .override_o    (override),
    .rdata_o       (rdata_o),
    .rdata_oe_o    (rdata_oe_o)
  );

  scd_drv_ctl #(
    .NUM_CH (P_NUM_CH)
  ) i_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .drv_ctl_i (drv_ctl_i),
    .drv_en_o  (drv_en_o)
  );

  // status override hides the read from the channel core
  assign ch_cs_o = override ? '0 : ch_sel;
  assign ch_rd_o = rd_i && hit && !override;
  assign ch_wr_o = wr_i && hit;
endmodule

// File: rtl/scd_checker.sv
module scd_checker #(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 4,
  parameter int DATA_W = 8,
  parameter int REG_AW = 3,
  localparam int CH_AW  = $clog2(NUM_CH),
  localparam int BASE_W = ADDR_W - REG_AW - CH_AW
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [BASE_W-1:0] base_sw_i,
  input logic              status_mode_i,
  input logic [NUM_CH-1:0] ch_irq_i,
  input logic              irq_gate_i,
  input logic [NUM_CH-1:0] drv_ctl_i,
  input logic [NUM_CH-1:0] ch_cs_o,
  input logic [REG_AW-1:0] ch_reg_o,
  input logic              ch_rd_o,
  input logic              ch_wr_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rdata_oe_o,
  input logic              irq_o,
  input logic [NUM_CH-1:0] drv_en_o
);
  logic scratch_ofs;
  assign scratch_ofs = (addr_i[REG_AW-1:0] == {REG_AW{1'b1}});

  // an address equal to the switch pattern fails every ON/OFF rule
  assert_no_select_on_mismatch_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[ADDR_W-1 -: BASE_W] == base_sw_i) |-> (ch_cs_o == '0 && !rdata_oe_o && !ch_wr_o));

  assert_cs_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_cs_o));

  assert_reg_follows_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ch_rd_o || ch_wr_o) |-> (ch_reg_o == addr_i[REG_AW-1:0]));

  assert_override_hides_channel_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_oe_o && status_mode_i && scratch_ofs) |-> (ch_cs_o == '0 && !ch_rd_o && rdata_o[DATA_W-1:NUM_CH] == '0));

  assert_scratch_write_passes_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ch_wr_o |-> ($countones(ch_cs_o) == 1));

  assert_irq_follows_req_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_irq_i) |=> (irq_o == irq_gate_i));

  assert_drv_en_delay_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (drv_en_o == $past(drv_ctl_i)));

  always_comb begin
    if (!rst_ni) begin
      assert_reset_quiet_R11: assert (!irq_o && drv_en_o == '0);
    end
  end
endmodule

bind serial_card_decoder scd_checker #(
  .ADDR_W (P_ADDR_W),
  .NUM_CH (P_NUM_CH),
  .DATA_W (P_DATA_W),
  .REG_AW (P_REG_AW)
) i_scd_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .rd_i          (rd_i),
  .wr_i          (wr_i),
  .base_sw_i     (base_sw_i),
  .status_mode_i (status_mode_i),
  .ch_irq_i      (ch_irq_i),
  .irq_gate_i    (irq_gate_i),
  .drv_ctl_i     (drv_ctl_i),
  .ch_cs_o       (ch_cs_o),
  .ch_reg_o      (ch_reg_o),
  .ch_rd_o       (ch_rd_o),
  .ch_wr_o       (ch_wr_o),
  .rdata_o       (rdata_o),
  .rdata_oe_o    (rdata_oe_o),
  .irq_o         (irq_o),
  .drv_en_o      (drv_en_o)
);

// File: tb/test_serial_card_decoder.sv
`timescale 1ns/1ps
module test_serial_card_decoder;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr_i = '0;
  logic        rd_i = 1'b0;
  logic        wr_i = 1'b0;
  logic [10:0] base_sw_i = '0;
  logic        status_mode_i = 1'b0;
  logic [31:0] ch_rdata_i = '0;
  logic [3:0]  ch_irq_i = '0;
  logic        irq_gate_i = 1'b0;
  logic [3:0]  drv_ctl_i = '0;
  logic [3:0]  ch_cs_o;
  logic [2:0]  ch_reg_o;
  logic        ch_rd_o;
  logic        ch_wr_o;
  logic [7:0]  rdata_o;
  logic        rdata_oe_o;
  logic        irq_o;
  logic [3:0]  drv_en_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk_i = ~clk_i;

  serial_card_decoder i_serial_card_decoder (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic bit f_hit(logic [15:0] a, logic [10:0] sw);
    return a[15:5] == ~sw;
  endfunction

  function automatic bit f_ovr(logic [15:0] a, logic [10:0] sw, logic rd, logic md);
    return rd && f_hit(a, sw) && md && (a[2:0] == 3'd7);
  endfunction

  function automatic logic [3:0] f_cs(logic [15:0] a, logic [10:0] sw, logic rd, logic md);
    if (!f_hit(a, sw) || f_ovr(a, sw, rd, md)) return 4'd0;
    return 4'd1 << a[4:3];
  endfunction

  function automatic logic [7:0] f_rdata(logic [15:0] a, logic [10:0] sw, logic rd, logic md,
                                         logic [3:0] irq, logic [31:0] chd);
    if (!(rd && f_hit(a, sw))) return 8'd0;
    if (f_ovr(a, sw, rd, md)) return {4'd0, irq};
    return chd[a[4:3]*8 +: 8];
  endfunction

  // inputs were driven before this edge; compare 2 ns after it
  task automatic step_check();
    @(posedge clk_i);
    #2;
    chk(ch_cs_o == f_cs(addr_i, base_sw_i, rd_i, status_mode_i), "R2 cs",
        32'(ch_cs_o), 32'(f_cs(addr_i, base_sw_i, rd_i, status_mode_i)));
    chk(ch_reg_o == addr_i[2:0], "R3 reg", 32'(ch_reg_o), 32'(addr_i[2:0]));
    chk(ch_rd_o == (rd_i && f_hit(addr_i, base_sw_i) && !f_ovr(addr_i, base_sw_i, rd_i, status_mode_i)),
        "R3 rd", 32'(ch_rd_o), 32'(rd_i));
    chk(ch_wr_o == (wr_i && f_hit(addr_i, base_sw_i)), "R8 wr", 32'(ch_wr_o), 32'(wr_i));
    chk(rdata_oe_o == (rd_i && f_hit(addr_i, base_sw_i)), "R1 oe", 32'(rdata_oe_o), 32'(rd_i));
    chk(rdata_o == f_rdata(addr_i, base_sw_i, rd_i, status_mode_i, ch_irq_i, ch_rdata_i), "R4 rdata",
        32'(rdata_o), 32'(f_rdata(addr_i, base_sw_i, rd_i, status_mode_i, ch_irq_i, ch_rdata_i)));
    chk(irq_o == (irq_gate_i && |ch_irq_i), "R9 irq", 32'(irq_o), 32'(irq_gate_i && |ch_irq_i));
    chk(drv_en_o == drv_ctl_i, "R10 drv", 32'(drv_en_o), 32'(drv_ctl_i));
  endtask

  localparam logic [15:0] BASE = 16'h0300;

  initial begin
    logic [15:0] a;
    logic [7:0]  exp_st;
    void'($urandom(32'h5eed_0042));
    base_sw_i  = ~BASE[15:5];
    ch_rdata_i = 32'hD4C3_B2A1;
    ch_irq_i   = 4'b1011;
    drv_ctl_i  = 4'b1111;
    irq_gate_i = 1'b1;
    repeat (3) @(posedge clk_i);
    #2;
    chk(irq_o == 1'b0, "R11 irq in reset", 32'(irq_o), 0);
    chk(drv_en_o == 4'd0, "R11 drv in reset", 32'(drv_en_o), 0);
    addr_i = BASE + 16'd7; rd_i = 1'b1; status_mode_i = 1'b1;
    #1;
    chk(rdata_o == 8'd0, "R11 status in reset", 32'(rdata_o), 0);
    rd_i = 1'b0;
    rst_ni = 1'b1;

    // R2 R4 R7: every channel, every offset, mode off
    status_mode_i = 1'b0;
    for (int c = 0; c < 4; c++) begin
      for (int o = 0; o < 8; o++) begin
        ch_rdata_i = $urandom;
        addr_i = BASE + 16'(c*8 + o);
        rd_i = 1'b1;
        step_check();
        chk(ch_cs_o == (4'd1 << c), "R2 channel window", 32'(ch_cs_o), 32'(4'd1 << c));
      end
    end
    rd_i = 1'b0;

    // R6: status override on offset 7 of each channel
    status_mode_i = 1'b1;
    for (int c = 0; c < 4; c++) begin
      ch_irq_i = 4'(c + 5);
      addr_i = BASE + 16'(c*8 + 7);
      rd_i = 1'b1;
      step_check();
      chk(rdata_o == {4'd0, 4'(c + 5)} && ch_cs_o == 4'd0, "R6 override",
          32'({ch_cs_o, rdata_o}), 32'(c + 5));
    end
    rd_i = 1'b0;

    // R8: scratchpad write reaches channel with mode on
    addr_i = BASE + 16'd23; wr_i = 1'b1;
    step_check();
    chk(ch_wr_o && ch_cs_o == 4'b0100, "R8 scratch write", 32'({ch_wr_o, ch_cs_o}), 32'h14);
    wr_i = 1'b0;

    // R5: status captured one edge later, upper bits zero
    ch_irq_i = 4'b0001;
    addr_i = BASE + 16'd7; rd_i = 1'b1;
    step_check();
    ch_irq_i = 4'b1110;
    #1;
    chk(rdata_o == 8'h01, "R5 before edge", 32'(rdata_o), 32'h01);
    step_check();
    chk(rdata_o == 8'h0E, "R5 after edge", 32'(rdata_o), 32'h0E);
    rd_i = 1'b0;

    // R9: gate off suppresses shared irq
    irq_gate_i = 1'b0;
    step_check();
    chk(irq_o == 1'b0, "R9 gated", 32'(irq_o), 0);
    irq_gate_i = 1'b1;
    ch_irq_i = 4'd0;
    step_check();
    chk(irq_o == 1'b0, "R9 no request", 32'(irq_o), 0);

    // R1: edges of the window and extreme switch settings
    rd_i = 1'b1;
    addr_i = BASE - 16'd1;
    step_check();
    chk(rdata_oe_o == 1'b0 && ch_cs_o == 4'd0, "R1 below base", 32'(ch_cs_o), 0);
    addr_i = BASE + 16'd32;
    step_check();
    chk(rdata_oe_o == 1'b0 && ch_cs_o == 4'd0, "R1 above window", 32'(ch_cs_o), 0);
    base_sw_i = 11'h7FF;
    addr_i = 16'h0019;
    step_check();
    chk(ch_cs_o == 4'b1000, "R1 all ON at zero", 32'(ch_cs_o), 32'h8);
    base_sw_i = 11'h000;
    addr_i = 16'hFFE0;
    step_check();
    chk(ch_cs_o == 4'b0001, "R1 all OFF at top", 32'(ch_cs_o), 32'h1);
    rd_i = 1'b0;

    // random mix around and away from the window
    base_sw_i = ~BASE[15:5];
    for (int i = 0; i < 400; i++) begin
      int op;
      a = ($urandom % 2) ? BASE + 16'($urandom % 40) - 16'd4 : 16'($urandom);
      op = int'($urandom % 4);
      addr_i = a;
      rd_i = (op == 1 || op == 3);
      wr_i = (op == 2);
      status_mode_i = 1'($urandom);
      ch_irq_i = 4'($urandom);
      irq_gate_i = 1'($urandom);
      drv_ctl_i = 4'($urandom);
      ch_rdata_i = $urandom;
      step_check();
    end
    rd_i = 1'b0; wr_i = 1'b0;

    // R10: driver enables track control bits one edge later
    drv_ctl_i = 4'b0101;
    step_check();
    drv_ctl_i = 4'b1010;
    #1;
    chk(drv_en_o == 4'b0101, "R10 hold until edge", 32'(drv_en_o), 32'h5);
    step_check();

    exp_st = 8'd0;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #200_000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule